// File: doc/BRIEF.md
# Divided-clock System Counter with Single Compare Timer

This block holds a 64-bit counter that runs freely from reset and advances once every three cycles of its input clock, through an internal prescaler. Software reaches it over a plain 32-bit register port with separate read and write strobes. It can read the counter as two live 32-bit words and arm a single compare frame that raises a level interrupt once the counter reaches a programmed value.

To arm a compare event, software first clears the enable bit, writes the upper compare word and then the lower one, and sets enable again. Once the counter has caught up with the compare value, a read-only status flag sets. The interrupt output then follows that flag unless the mask bit is set. Writing the enable bit as zero is the only way to acknowledge the event: it clears the flag and drops the interrupt. The counter words are not latched against each other. Software reads the upper word, the lower word and the upper word again, and retries if the two upper values differ.

Top module: `sysctr_cmp_timer`

## Requirements
- R1: After reset the counter, both compare words, the control bits and the status flag are zero, `irq` is low and `rdata` is zero.
- R2: The counter increments by exactly one on every third rising clock edge after reset is released. It first becomes 1 on the third edge and never changes on any other edge.
- R3: The counter low word reads at byte address 0x08 and the high word at 0x0C. Each read returns the value the counter held when the read strobe was sampled. Writes to these addresses have no effect on the count.
- R4: The compare low word sits at 0x10020 and the compare high word at 0x10024, and both can be written and read back. Only bits [19:0] of the high word are stored, so bits [31:20] of the high word read as zero.
- R5: The control register at 0x1002C has enable in bit 0 and interrupt mask in bit 1, both writable. Bit 2 is the status flag and is read-only. All other bits read as zero, and writes to bit 2 and above have no effect.
- R6: While enable is 1, the status flag sets on the prescaled tick edge at which the counter becomes greater than or equal to the compare value. If the compare value is already reached when enable is written to 1, the flag sets on the next tick edge.
- R7: `irq` is high exactly when status is 1, enable is 1 and mask is 0. It stays high as a level until one of these changes.
- R8: A control write with bit 0 equal to 0 clears the status flag, and `irq` is low from that edge on. When that write lands on the same tick edge that would set the flag, the clear takes priority.
- R9: Read data is registered and appears on `rdata` the cycle after `rd_en` is sampled. Reads of any address not listed above return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; the counter advances once per three cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe, sampled on the rising edge |
| addr | input | ADDR_W (20) | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Level interrupt request |

## Verification
The collision that matters is a control write that clears enable landing on the same edge as the prescaled tick that would set the status flag. The bench provokes it with a past compare value. It aligns itself to the edge count, writes enable on an edge one after a tick, and writes enable as zero exactly two edges later, which is the next tick. It judges the result by `irq` staying low across that edge and later ones, and by the status bit reading back as zero. Counter reads are compared against a model derived only from the number of clock edges since reset.

// File: rtl/sysctr_cmp_timer.sv
module sysctr_cmp_timer #(
  parameter int ADDR_W      = 20,
  parameter int DIV         = 3,
  parameter int CMP_HI_BITS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);

  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

  localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'('h0_0008);
  localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'('h0_000C);
  localparam logic [ADDR_W-1:0] A_CMP_LO = ADDR_W'('h1_0020);
  localparam logic [ADDR_W-1:0] A_CMP_HI = ADDR_W'('h1_0024);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'('h1_002C);

  logic [DIV_W-1:0]       div_q;
  logic [63:0]            cnt_q;
  logic [31:0]            cmp_lo_q;
  logic [CMP_HI_BITS-1:0] cmp_hi_q;
  logic                   en_q, mask_q, stat_q;

  logic        tick;
  logic [63:0] cnt_nxt;
  logic [63:0] cmp_full;
  logic        ctrl_wr;
  logic [31:0] rd_mux;

  assign tick     = (div_q == DIV_LAST);
  assign cnt_nxt  = cnt_q + 64'd1;
  assign cmp_full = {{(32 - CMP_HI_BITS){1'b0}}, cmp_hi_q, cmp_lo_q};
  assign ctrl_wr  = wr_en && (addr == A_CTRL);
  assign irq      = stat_q && en_q && !mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (tick) begin
      div_q <= '0;
      cnt_q <= cnt_nxt;
    end else begin
      div_q <= div_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_lo_q <= '0;
      cmp_hi_q <= '0;
      en_q     <= 1'b0;
      mask_q   <= 1'b0;
    end else if (wr_en) begin
      if (addr == A_CMP_LO) cmp_lo_q <= wdata;
      if (addr == A_CMP_HI) cmp_hi_q <= wdata[CMP_HI_BITS-1:0];
      if (ctrl_wr) begin
        en_q   <= wdata[0];
        mask_q <= wdata[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      stat_q <= 1'b0;
    else if (ctrl_wr && !wdata[0])
      stat_q <= 1'b0;
    else if (tick && en_q && (cnt_nxt >= cmp_full))
      stat_q <= 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CNT_LO: rd_mux = cnt_q[31:0];
      A_CNT_HI: rd_mux = cnt_q[63:32];
      A_CMP_LO: rd_mux = cmp_lo_q;
      A_CMP_HI: rd_mux = 32'(cmp_hi_q);
      A_CTRL:   rd_mux = {29'd0, stat_q, mask_q, en_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata <= '0;
    else if (rd_en)
      rdata <= rd_mux;
  end

endmodule

// File: rtl/sysctr_cmp_timer_chk.sv
module sysctr_cmp_timer_chk #(
  parameter int ADDR_W = 20,
  parameter int DIV    = 3,
  parameter int DIV_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              irq,
  input logic [63:0]       cnt,
  input logic [DIV_W-1:0]  div,
  input logic              en,
  input logic              status
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'('h1_002C);

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    div < DIV_W'(DIV)); // R2

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 64'd1 && $past(div) == DIV_W'(DIV - 1))); // R2

  AST_SET_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status) |-> ($past(div) == DIV_W'(DIV - 1))); // R6

  AST_STAT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    status |-> en); // R8

  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CTRL_ADDR && !wdata[0]) |=> !irq); // R8

endmodule

bind sysctr_cmp_timer sysctr_cmp_timer_chk #(
  .ADDR_W(ADDR_W), .DIV(DIV), .DIV_W(DIV_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .cnt(cnt_q), .div(div_q), .en(en_q), .status(stat_q)
);

// File: tb/sysctr_cmp_timer_tb_top.sv
`timescale 1ns/1ps
module sysctr_cmp_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [19:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int ntests = 0;
  int nfail  = 0;
  int ecount = 0;

  always #2 clk = ~clk;

  always @(posedge clk) if (rst_n) ecount <= ecount + 1;

  sysctr_cmp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [19:0] a, output logic [31:0] v);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic align3;
    while (ecount % 3 != 0) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 irq in reset", {31'd0, irq}, 32'd0);
    check("R1 rdata in reset", rdata, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(20'h1002C, v); check("R1 ctrl after reset", v, 32'd0);
    rd(20'h10020, v); check("R1 cmp lo after reset", v, 32'd0);
    rd(20'h10024, v); check("R1 cmp hi after reset", v, 32'd0);
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_count;
    logic [31:0] v;
    int e0;
    for (int gap = 0; gap < 6; gap++) begin
      repeat (gap) @(negedge clk);
      e0 = ecount;
      rd(20'h00008, v);
      check("R2 R3 counter low word", v, 32'(e0 / 3));
    end
    rd(20'h0000C, v); check("R3 counter high word", v, 32'd0);
    wr(20'h00008, 32'h0000FFFF);
    wr(20'h0000C, 32'h12345678);
    e0 = ecount;
    rd(20'h00008, v); check("R3 write to counter ignored", v, 32'(e0 / 3));
    rd(20'h0000C, v); check("R3 write to counter high ignored", v, 32'd0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(20'h10020, 32'hA5A51234);
    rd(20'h10020, v); check("R4 cmp lo readback", v, 32'hA5A51234);
    wr(20'h10024, 32'hFFF80001);
    rd(20'h10024, v); check("R4 cmp hi keeps 20 bits", v, 32'h00080001);
    wr(20'h1002C, 32'hFFFFFFFE);
    rd(20'h1002C, v); check("R5 ctrl readback mask only", v, 32'h00000002);
    check("R5 no irq with enable low", {31'd0, irq}, 32'd0);
    wr(20'h1002C, 32'h0);
    wr(20'h10024, 32'h0);
    rd(20'h10028, v); check("R9 unmapped 0x10028", v, 32'd0);
    rd(20'h00000, v); check("R9 unmapped 0x0", v, 32'd0);
    rd(20'h10030, v); check("R9 unmapped 0x10030", v, 32'd0);
  endtask

  task automatic t_fire;
    logic [31:0] v;
    int c;
    c = ecount / 3 + 6;
    wr(20'h1002C, 32'h0);
    wr(20'h10024, 32'h0);
    wr(20'h10020, 32'(c));
    wr(20'h1002C, 32'h1);
    while (ecount < 3 * c - 1) @(negedge clk);
    check("R6 irq low before compare", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check("R6 R7 irq on compare tick", {31'd0, irq}, 32'd1);
    repeat (4) @(negedge clk);
    check("R7 irq holds as level", {31'd0, irq}, 32'd1);
    rd(20'h1002C, v); check("R5 R6 status bit set", v, 32'h5);
    wr(20'h1002C, 32'h3);
    check("R7 mask hides irq", {31'd0, irq}, 32'd0);
    rd(20'h1002C, v); check("R7 status kept while masked", v, 32'h7);
    wr(20'h1002C, 32'h1);
    check("R7 unmask restores irq", {31'd0, irq}, 32'd1);
    wr(20'h1002C, 32'h0);
    check("R8 ack drops irq", {31'd0, irq}, 32'd0);
    rd(20'h1002C, v); check("R8 ack clears status", v, 32'h0);
  endtask

  task automatic t_past;
    wr(20'h10020, 32'h0);
    align3;
    wr(20'h1002C, 32'h1);
    check("R6 past compare no early set", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check("R6 past compare still waiting", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check("R6 past compare sets on next tick", {31'd0, irq}, 32'd1);
    wr(20'h1002C, 32'h0);
    check("R8 ack after past compare", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_race;
    logic [31:0] v;
    align3;
    wr(20'h1002C, 32'h1);
    @(negedge clk);
    wr(20'h1002C, 32'h0);
    check("R8 clear wins over tick", {31'd0, irq}, 32'd0);
    repeat (4) @(negedge clk);
    check("R8 irq stays low after race", {31'd0, irq}, 32'd0);
    rd(20'h1002C, v); check("R8 status clear after race", v, 32'h0);
  endtask

  initial begin
    t_reset;
    t_count;
    t_regs;
    t_fire;
    t_past;
    t_race;
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    ntests++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

endmodule